// File: doc/BRIEF.md
# Power-Manager Command Dispatcher

This block sits behind a host transport that has already collected one complete command: an opcode byte, up to 32 argument bytes and the count of those bytes. On a one-cycle dispatch strobe it decodes the opcode, checks the argument count the opcode needs, performs the action and registers a response of up to four bytes with its length. A done pulse marks the response as valid. The response stays unchanged until the next strobe.

The block keeps a 32-bit seconds clock counted from the start of 1904. The clock advances on an external one-second enable. Commands can read the clock and load it. Shutdown and reboot requests leave the block as single-cycle pulses. Autopoll control for the peripheral serial bus is held in two registers. Ordinary serial-bus packets are passed on to an external transaction engine as a forward strobe with a reformatted payload. Opcodes that are not implemented return a block of zeros whose length is worked out from the opcode.

Top module: `pmcmd_dispatch`

## Requirements
- R1: `rsp_done` is high for exactly the one cycle after each `disp_valid` cycle. `rsp_len` and `rsp_data` change only in that cycle and then hold until the next dispatch.
- R2: After reset, `rsp_done`, `rsp_len`, `rsp_data`, `off_req`, `rst_req`, `fwd_valid`, `apoll_en` and `apoll_mask` are all zero. The seconds clock holds `UNIX_BASE + 2082844800` (0x7C25B080 with the default `UNIX_BASE` of 0).
- R3: Opcode 0x38 with zero arguments returns 4 bytes holding the clock value, most significant byte in `rsp_data[7:0]`. The clock value is sampled in the strobe cycle.
- R4: Each `sec_tick` cycle adds one to the clock. Opcode 0x30 with exactly 4 arguments loads the clock from argument bytes 0..3, most significant first (byte i is `disp_args[8i+7:8i]`), and returns 0 bytes. A load in a tick cycle stores the loaded value unchanged.
- R5: Opcode 0x7E with 4 arguments returns one 0x00 byte. It pulses `off_req` with `rsp_done` only when the arguments are 0x4D, 0x41, 0x54, 0x54 in that order.
- R6: Opcode 0xD0 with zero arguments returns 0 bytes and pulses `rst_req` with `rsp_done`.
- R7: Opcodes 0xEA, 0xDC and 0xE2 return the single bytes 0x01, 0x00 and 0x62 for any argument count.
- R8: Opcode 0x8F needs at least one argument. Subcommands 0 and 3 return two 0x00 bytes. Subcommands 1, 2, 4, 5 and any other value return 0 bytes.
- R9: Opcode 0x20 with exactly 4 arguments starting 0x00, 0x86 is an autopoll setup. Bytes 2..3 form a mask, most significant first. A non-zero mask loads `apoll_mask` and sets `apoll_en`. A zero mask clears `apoll_en` and keeps `apoll_mask`. The response has 0 bytes and no forward is made.
- R10: Any other opcode 0x20 packet with at least 2 arguments, whose byte 2 is at most argc-3, pulses `fwd_valid`. `fwd_len` is argc-2. `fwd_data` byte 0 is argument byte 0, and `fwd_data` byte k (k≥1) is argument byte k+2. The response has 0 bytes.
- R11: A command that fails its count rule (0x38 and 0xD0 need 0; 0x30 and 0x7E need 4; 0x8F needs ≥1; 0x20 needs ≥2, exactly 4 with the autopoll prefix, and otherwise byte 2 ≤ argc-3) returns 0 bytes and changes neither the clock nor the autopoll state. It also raises no request or forward pulse.
- R12: Any other opcode returns zeros. It returns 0 bytes when opcode bits [7:6] are 11. Otherwise it returns opcode bits [1:0] bytes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sec_tick | input | 1 | One-second enable for the clock |
| disp_valid | input | 1 | Dispatch strobe for a complete command |
| disp_op | input | 8 | Opcode |
| disp_argc | input | 6 | Number of valid argument bytes |
| disp_args | input | 256 | Argument bytes, byte i at bits [8i+7:8i] |
| rsp_done | output | 1 | Response valid pulse |
| rsp_len | output | 3 | Response byte count |
| rsp_data | output | 32 | Response bytes, byte 0 in bits [7:0] |
| off_req | output | 1 | Power-off request pulse |
| rst_req | output | 1 | System reset request pulse |
| apoll_en | output | 1 | Autopoll enabled |
| apoll_mask | output | 16 | Autopoll device mask |
| fwd_valid | output | 1 | Serial-bus packet forward pulse |
| fwd_len | output | 6 | Forwarded packet length |
| fwd_data | output | 240 | Forwarded packet bytes, byte 0 in bits [7:0] |

## Verification
A wrong decode or a wrong count check shows in the very next cycle as a wrong `rsp_len`, or as a stray or missing request, forward or autopoll change, so each opcode is swept across argument counts. A corrupted clock register stays hidden until the next read-clock command, which is why every load, tick and rejected load is followed by a read. Swapped byte lanes show only for values whose bytes differ. Every opcode outside the handled set is swept to confirm the computed fill length and the all-zero payload.

// File: rtl/pmc_pkg.sv
// Shared opcodes, constants and decode types for the power-manager dispatcher.
package pmc_pkg;
    // Command opcodes
    localparam logic [7:0] OP_CLK_GET  = 8'h38;
    localparam logic [7:0] OP_CLK_SET  = 8'h30;
    localparam logic [7:0] OP_OFF      = 8'h7E;
    localparam logic [7:0] OP_REBOOT   = 8'hD0;
    localparam logic [7:0] OP_VERSION  = 8'hEA;
    localparam logic [7:0] OP_COVER    = 8'hDC;
    localparam logic [7:0] OP_DLSTAT   = 8'hE2;
    localparam logic [7:0] OP_PWR_EV   = 8'h8F;
    localparam logic [7:0] OP_SBUS     = 8'h20;

    // Power-event subcommands that return data
    localparam logic [7:0] PWR_GET_UP   = 8'h00;
    localparam logic [7:0] PWR_GET_WAKE = 8'h03;

    // Constant replies
    localparam logic [7:0] VERSION_BYTE = 8'h01;
    localparam logic [7:0] COVER_BYTE   = 8'h00;
    localparam logic [7:0] DLSTAT_BYTE  = 8'h62;

    // Autopoll packet prefix
    localparam logic [7:0] APOLL_B0 = 8'h00;
    localparam logic [7:0] APOLL_B1 = 8'h86;

    // Seconds between the 1904 epoch and the 1970 epoch
    localparam logic [31:0] EPOCH_SHIFT = 32'd2082844800;

    typedef enum logic [3:0] {
        ACT_NONE,
        ACT_CLK_GET,
        ACT_CLK_SET,
        ACT_OFF,
        ACT_REBOOT,
        ACT_CONST,
        ACT_PWR_GET,
        ACT_APOLL,
        ACT_FWD,
        ACT_FILL
    } act_e;

    typedef struct packed {
        act_e        act;
        logic [7:0]  cbyte;
        logic [2:0]  fill;
        logic        sig;
    } dec_t;
endpackage

// File: rtl/pmc_decode.sv
// Opcode decoder and argument-count checker.
// Purely combinational. It maps opcode, count and the first four argument
// bytes to one action. A command that fails its count rule maps to ACT_NONE.
// Assumes argc never exceeds the argument buffer size.
module pmc_decode
    import pmc_pkg::*;
#(
    parameter int LEN_W = 6
) (
    input  logic [7:0]       op,
    input  logic [LEN_W-1:0] argc,
    input  logic [7:0]       a0,
    input  logic [7:0]       a1,
    input  logic [7:0]       a2,
    input  logic [7:0]       a3,
    output dec_t             dec
);
    logic argc_zero;
    logic argc_four;
    logic argc_two_up;
    logic sig_ok;
    logic apoll_prefix;
    logic fwd_fits;

    assign argc_zero    = (argc == '0);
    assign argc_four    = (argc == LEN_W'(4));
    assign argc_two_up  = (argc >= LEN_W'(2));
    assign sig_ok       = (a0 == 8'h4D) && (a1 == 8'h41) && (a2 == 8'h54) && (a3 == 8'h54);
    assign apoll_prefix = (a0 == APOLL_B0) && (a1 == APOLL_B1);
    assign fwd_fits     = (int'(a2) + 3) <= int'(argc);

    // Select the action for this opcode, honouring the count rules
    always_comb begin
        dec       = '0;
        dec.act   = ACT_NONE;
        dec.fill  = {1'b0, op[1:0]};
        dec.sig   = sig_ok;
        case (op)
            OP_CLK_GET: if (argc_zero) dec.act = ACT_CLK_GET;
            OP_CLK_SET: if (argc_four) dec.act = ACT_CLK_SET;
            OP_OFF:     if (argc_four) dec.act = ACT_OFF;
            OP_REBOOT:  if (argc_zero) dec.act = ACT_REBOOT;
            OP_VERSION: begin
                dec.act   = ACT_CONST;
                dec.cbyte = VERSION_BYTE;
            end
            OP_COVER: begin
                dec.act   = ACT_CONST;
                dec.cbyte = COVER_BYTE;
            end
            OP_DLSTAT: begin
                dec.act   = ACT_CONST;
                dec.cbyte = DLSTAT_BYTE;
            end
            OP_PWR_EV: begin
                if (!argc_zero && ((a0 == PWR_GET_UP) || (a0 == PWR_GET_WAKE))) begin
                    dec.act = ACT_PWR_GET;
                end
            end
            OP_SBUS: begin
                if (argc_two_up) begin
                    if (apoll_prefix) begin
                        if (argc_four) dec.act = ACT_APOLL;
                    end else if (fwd_fits) begin
                        dec.act = ACT_FWD;
                    end
                end
            end
            default: if (op[7:6] != 2'b11) dec.act = ACT_FILL;
        endcase
    end
endmodule

// File: rtl/pmc_seconds.sv
// Seconds clock register.
// Counts one per tick enable. A load replaces the value and takes priority
// over a tick in the same cycle. Resets to INIT.
module pmc_seconds #(
    parameter int             W    = 32,
    parameter logic [W-1:0]   INIT = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic [W-1:0] count
);
    // Advance or load the seconds count
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= INIT;
        end else if (load) begin
            count <= load_val;
        end else if (tick) begin
            count <= count + W'(1);
        end
    end
endmodule

// File: rtl/pmc_rsp.sv
// Response builder and request-pulse generator.
// Registers the response length and bytes one cycle after the strobe and
// holds them until the next strobe. Raises shutdown and reboot pulses with
// the done pulse. Assumes RSP_BYTES is at least 4.
module pmc_rsp
    import pmc_pkg::*;
#(
    parameter int RSP_BYTES = 4,
    parameter int RSP_LEN_W = 3
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   strobe,
    input  dec_t                   dec,
    input  logic [31:0]            now,
    output logic                   done,
    output logic [RSP_LEN_W-1:0]   len,
    output logic [8*RSP_BYTES-1:0] data,
    output logic                   off_req,
    output logic                   rst_req
);
    logic [RSP_BYTES-1:0][7:0] lane_d;
    logic [RSP_LEN_W-1:0]      len_d;

    // Per-lane next byte: clock bytes most significant first, constant in lane 0
    for (genvar i = 0; i < RSP_BYTES; i++) begin : g_lane
        if (i < 4) begin : g_time
            assign lane_d[i] = (dec.act == ACT_CLK_GET) ? now[8*(3-i) +: 8] :
                               ((i == 0) && (dec.act == ACT_CONST)) ? dec.cbyte : 8'h00;
        end else begin : g_pad
            assign lane_d[i] = 8'h00;
        end
    end

    // Response length for each action
    always_comb begin
        case (dec.act)
            ACT_CLK_GET:         len_d = RSP_LEN_W'(4);
            ACT_OFF, ACT_CONST:  len_d = RSP_LEN_W'(1);
            ACT_PWR_GET:         len_d = RSP_LEN_W'(2);
            ACT_FILL:            len_d = RSP_LEN_W'(dec.fill);
            default:             len_d = '0;
        endcase
    end

    // Capture the response and mark it done
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done <= 1'b0;
            len  <= '0;
            data <= '0;
        end else begin
            done <= strobe;
            if (strobe) begin
                len  <= len_d;
                data <= lane_d;
            end
        end
    end

    // Single-cycle shutdown and reboot requests
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            off_req <= 1'b0;
            rst_req <= 1'b0;
        end else begin
            off_req <= strobe && (dec.act == ACT_OFF) && dec.sig;
            rst_req <= strobe && (dec.act == ACT_REBOOT);
        end
    end
endmodule

// File: rtl/pmc_sbus_port.sv
// Serial-bus side of the dispatcher.
// Keeps the autopoll enable and mask. Reformats ordinary packets for the
// external transaction engine: the address byte, then the payload from
// argument byte 3 onward. Assumes ARG_MAX is at least 4.
module pmc_sbus_port
    import pmc_pkg::*;
#(
    parameter int ARG_MAX = 32,
    parameter int LEN_W   = 6
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      strobe,
    input  act_e                      act,
    input  logic [LEN_W-1:0]          argc,
    input  logic [7:0]                addr_byte,
    input  logic [15:0]               mask_in,
    input  logic [8*(ARG_MAX-3)-1:0]  payload,
    output logic                      apoll_en,
    output logic [15:0]               apoll_mask,
    output logic                      fwd_valid,
    output logic [LEN_W-1:0]          fwd_len,
    output logic [8*(ARG_MAX-2)-1:0]  fwd_data
);
    logic apoll_hit;
    logic fwd_hit;

    assign apoll_hit = strobe && (act == ACT_APOLL);
    assign fwd_hit   = strobe && (act == ACT_FWD);

    // Autopoll enable and mask update
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            apoll_en   <= 1'b0;
            apoll_mask <= '0;
        end else if (apoll_hit) begin
            if (mask_in != '0) begin
                apoll_en   <= 1'b1;
                apoll_mask <= mask_in;
            end else begin
                apoll_en   <= 1'b0;
            end
        end
    end

    // Forward pulse and packet capture
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fwd_valid <= 1'b0;
            fwd_len   <= '0;
            fwd_data  <= '0;
        end else begin
            fwd_valid <= fwd_hit;
            if (fwd_hit) begin
                fwd_len  <= argc - LEN_W'(2);
                fwd_data <= {payload, addr_byte};
            end
        end
    end
endmodule

// File: rtl/pmcmd_dispatch.sv
// Power-manager command dispatcher, top level.
// Takes one fully received command per strobe. Decodes it, runs the
// handler and presents the response one cycle later with a done pulse.
// Holds the 1904-epoch seconds clock and the autopoll state.
// Assumes ARG_MAX >= 4 and RSP_BYTES >= 4.
module pmcmd_dispatch
    import pmc_pkg::*;
#(
    parameter int          ARG_MAX   = 32,
    parameter int          RSP_BYTES = 4,
    parameter logic [31:0] UNIX_BASE = 32'd0
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            sec_tick,
    input  logic                            disp_valid,
    input  logic [7:0]                      disp_op,
    input  logic [$clog2(ARG_MAX+1)-1:0]    disp_argc,
    input  logic [8*ARG_MAX-1:0]            disp_args,
    output logic                            rsp_done,
    output logic [$clog2(RSP_BYTES+1)-1:0]  rsp_len,
    output logic [8*RSP_BYTES-1:0]          rsp_data,
    output logic                            off_req,
    output logic                            rst_req,
    output logic                            apoll_en,
    output logic [15:0]                     apoll_mask,
    output logic                            fwd_valid,
    output logic [$clog2(ARG_MAX+1)-1:0]    fwd_len,
    output logic [8*(ARG_MAX-2)-1:0]        fwd_data
);
    localparam int          LEN_W     = $clog2(ARG_MAX + 1);
    localparam int          RSP_LEN_W = $clog2(RSP_BYTES + 1);
    localparam logic [31:0] TIME_INIT = UNIX_BASE + EPOCH_SHIFT;

    logic [7:0]  arg_b [4];
    dec_t        dec;
    logic [31:0] time_q;
    logic        clk_load;

    // First four argument bytes feed the decoder and the clock load
    for (genvar k = 0; k < 4; k++) begin : g_arg
        assign arg_b[k] = disp_args[8*k +: 8];
    end

    assign clk_load = disp_valid && (dec.act == ACT_CLK_SET);

    pmc_decode #(.LEN_W(LEN_W)) i_decode (
        .op   (disp_op),
        .argc (disp_argc),
        .a0   (arg_b[0]),
        .a1   (arg_b[1]),
        .a2   (arg_b[2]),
        .a3   (arg_b[3]),
        .dec  (dec)
    );

    pmc_seconds #(.W(32), .INIT(TIME_INIT)) i_seconds (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (sec_tick),
        .load     (clk_load),
        .load_val ({arg_b[0], arg_b[1], arg_b[2], arg_b[3]}),
        .count    (time_q)
    );

    pmc_rsp #(.RSP_BYTES(RSP_BYTES), .RSP_LEN_W(RSP_LEN_W)) i_rsp (
        .clk     (clk),
        .rst_n   (rst_n),
        .strobe  (disp_valid),
        .dec     (dec),
        .now     (time_q),
        .done    (rsp_done),
        .len     (rsp_len),
        .data    (rsp_data),
        .off_req (off_req),
        .rst_req (rst_req)
    );

    pmc_sbus_port #(.ARG_MAX(ARG_MAX), .LEN_W(LEN_W)) i_sbus (
        .clk        (clk),
        .rst_n      (rst_n),
        .strobe     (disp_valid),
        .act        (dec.act),
        .argc       (disp_argc),
        .addr_byte  (arg_b[0]),
        .mask_in    ({arg_b[2], arg_b[3]}),
        .payload    (disp_args[8*ARG_MAX-1:24]),
        .apoll_en   (apoll_en),
        .apoll_mask (apoll_mask),
        .fwd_valid  (fwd_valid),
        .fwd_len    (fwd_len),
        .fwd_data   (fwd_data)
    );
endmodule

// File: rtl/pmc_dispatch_chk.sv
// Protocol checker for the dispatcher, attached to the top by bind.
// Watches the ports and the seconds register. It drives nothing.
module pmc_dispatch_chk
    import pmc_pkg::*;
#(
    parameter int ARG_MAX   = 32,
    parameter int RSP_BYTES = 4
) (
    input logic                            clk,
    input logic                            rst_n,
    input logic                            sec_tick,
    input logic                            disp_valid,
    input logic [7:0]                      disp_op,
    input logic [$clog2(ARG_MAX+1)-1:0]    disp_argc,
    input logic                            rsp_done,
    input logic [$clog2(RSP_BYTES+1)-1:0]  rsp_len,
    input logic [7:0]                      rsp_byte0,
    input logic                            off_req,
    input logic                            rst_req,
    input logic                            fwd_valid,
    input logic                            apoll_en,
    input logic [31:0]                     time_q
);
    localparam int LEN_W = $clog2(ARG_MAX + 1);

    logic set_now;
    assign set_now = disp_valid && (disp_op == OP_CLK_SET) && (disp_argc == LEN_W'(4));

    assert_done_follows_R1: assert property (@(posedge clk) disable iff (!rst_n)
        disp_valid |=> rsp_done);

    assert_done_cause_R1: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done && $past(rst_n) |-> $past(disp_valid));

    assert_rsp_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_done && $past(rst_n) |-> $stable(rsp_len));

    assert_tick_adds_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && $past(sec_tick) && !$past(set_now) |-> time_q == $past(time_q) + 32'd1);

    assert_clock_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && !$past(sec_tick) && !$past(set_now) |-> $stable(time_q));

    assert_off_reply_R5: assert property (@(posedge clk) disable iff (!rst_n)
        off_req |-> rsp_done && (rsp_len == 1) && (rsp_byte0 == 8'h00));

    assert_reboot_reply_R6: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |-> rsp_done && (rsp_len == 0));

    assert_apoll_only_on_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_done && $past(rst_n) |-> $stable(apoll_en));

    assert_fwd_reply_R10: assert property (@(posedge clk) disable iff (!rst_n)
        fwd_valid |-> rsp_done && (rsp_len == 0));

    assert_one_side_effect_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({off_req, rst_req, fwd_valid}));

    assert_len_bound_R12: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_len <= 4);
endmodule

bind pmcmd_dispatch pmc_dispatch_chk #(.ARG_MAX(ARG_MAX), .RSP_BYTES(RSP_BYTES)) i_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .sec_tick   (sec_tick),
    .disp_valid (disp_valid),
    .disp_op    (disp_op),
    .disp_argc  (disp_argc),
    .rsp_done   (rsp_done),
    .rsp_len    (rsp_len),
    .rsp_byte0  (rsp_data[7:0]),
    .off_req    (off_req),
    .rst_req    (rst_req),
    .fwd_valid  (fwd_valid),
    .apoll_en   (apoll_en),
    .time_q     (time_q)
);

// File: tb/test_pmcmd_dispatch.sv
// Self-checking bench for the dispatcher: directed cases plus sweeps over
// opcodes, subcommands and argument counts.
module test_pmcmd_dispatch;
    localparam int ARG_MAX   = 32;
    localparam int RSP_BYTES = 4;
    localparam int LEN_W     = 6;

    logic                   clk = 1'b0;
    logic                   rst_n;
    logic                   sec_tick;
    logic                   disp_valid;
    logic [7:0]             disp_op;
    logic [LEN_W-1:0]       disp_argc;
    logic [8*ARG_MAX-1:0]   disp_args;
    logic                   rsp_done;
    logic [2:0]             rsp_len;
    logic [31:0]            rsp_data;
    logic                   off_req;
    logic                   rst_req;
    logic                   apoll_en;
    logic [15:0]            apoll_mask;
    logic                   fwd_valid;
    logic [LEN_W-1:0]       fwd_len;
    logic [8*(ARG_MAX-2)-1:0] fwd_data;

    int checks = 0;
    int errors = 0;
    logic [31:0] exp_time;

    always #5 clk = ~clk;

    pmcmd_dispatch i_pmcmd_dispatch (
        .clk(clk), .rst_n(rst_n), .sec_tick(sec_tick), .disp_valid(disp_valid),
        .disp_op(disp_op), .disp_argc(disp_argc), .disp_args(disp_args),
        .rsp_done(rsp_done), .rsp_len(rsp_len), .rsp_data(rsp_data),
        .off_req(off_req), .rst_req(rst_req), .apoll_en(apoll_en),
        .apoll_mask(apoll_mask), .fwd_valid(fwd_valid), .fwd_len(fwd_len),
        .fwd_data(fwd_data)
    );

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [8*ARG_MAX-1:0] pk(input logic [7:0] b0, input logic [7:0] b1,
                                                input logic [7:0] b2, input logic [7:0] b3,
                                                input logic [7:0] b4, input logic [7:0] b5);
        logic [8*ARG_MAX-1:0] r;
        r = '0;
        r[47:0] = {b5, b4, b3, b2, b1, b0};
        return r;
    endfunction

    function automatic logic [31:0] swap(input logic [31:0] v);
        return {v[7:0], v[15:8], v[23:16], v[31:24]};
    endfunction

    function automatic bit is_known(input logic [7:0] op);
        return op == 8'h38 || op == 8'h30 || op == 8'h7E || op == 8'hD0 || op == 8'hEA ||
               op == 8'hDC || op == 8'hE2 || op == 8'h8F || op == 8'h20;
    endfunction

    // Drive one command for one cycle; returns at the negedge after the capture edge
    task automatic send(input logic [7:0] op, input int n, input logic [8*ARG_MAX-1:0] a,
                        input logic tk);
        @(negedge clk);
        disp_valid = 1'b1; disp_op = op; disp_argc = LEN_W'(n); disp_args = a; sec_tick = tk;
        @(negedge clk);
        disp_valid = 1'b0; sec_tick = 1'b0;
    endtask

    task automatic tick();
        @(negedge clk); sec_tick = 1'b1;
        @(negedge clk); sec_tick = 1'b0;
        exp_time = exp_time + 32'd1;
    endtask

    task automatic read_clock(input string tag);
        send(8'h38, 0, '0, 1'b0);
        check({tag, " len"}, 64'(rsp_len), 64'd4);
        check({tag, " data"}, 64'(rsp_data), 64'(swap(exp_time)));
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++; errors++;
        $display("FAIL R1 watchdog actual=hung expected=finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        rst_n = 1'b0; sec_tick = 1'b0; disp_valid = 1'b0; disp_op = '0;
        disp_argc = '0; disp_args = '0;
        exp_time = 32'h7C25B080;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R2 reset state
        check("R2 done", 64'(rsp_done), 0);
        check("R2 len", 64'(rsp_len), 0);
        check("R2 data", 64'(rsp_data), 0);
        check("R2 pulses", 64'({off_req, rst_req, fwd_valid}), 0);
        check("R2 apoll", 64'({apoll_en, apoll_mask}), 0);

        // R3 read clock, R1 done timing and hold
        read_clock("R3 epoch");
        check("R1 done high", 64'(rsp_done), 1);
        @(negedge clk);
        check("R1 done low", 64'(rsp_done), 0);
        check("R1 len held", 64'(rsp_len), 4);

        // R4 ticks, loads and load during tick
        tick(); tick(); tick();
        read_clock("R4 ticks");
        send(8'h30, 4, pk(8'h12, 8'h34, 8'h56, 8'h78, 0, 0), 1'b0);
        check("R4 set len", 64'(rsp_len), 0);
        exp_time = 32'h12345678;
        read_clock("R4 after set");
        tick(); tick();
        read_clock("R4 set plus ticks");
        send(8'h30, 4, pk(8'hA1, 8'hB2, 8'hC3, 8'hD4, 0, 0), 1'b1);
        exp_time = 32'hA1B2C3D4;
        read_clock("R4 set wins tick");

        // R11 count sweep for the clock commands
        for (int n = 0; n <= 6; n++) begin
            if (n != 4) begin
                send(8'h30, n, pk(8'h55, 8'h66, 8'h77, 8'h88, 8'h99, 8'hAA), 1'b0);
                check("R11 bad set len", 64'(rsp_len), 0);
                read_clock("R11 clock untouched");
            end
            if (n != 0) begin
                send(8'h38, n, '0, 1'b0);
                check("R11 bad get len", 64'(rsp_len), 0);
            end
        end

        // R5 shutdown signature, R11 wrong count
        send(8'h7E, 4, pk(8'h4D, 8'h41, 8'h54, 8'h54, 0, 0), 1'b0);
        check("R5 off pulse", 64'(off_req), 1);
        check("R5 len", 64'(rsp_len), 1);
        check("R5 byte", 64'(rsp_data), 0);
        @(negedge clk);
        check("R5 pulse single", 64'(off_req), 0);
        send(8'h7E, 4, pk(8'h4D, 8'h41, 8'h54, 8'h58, 0, 0), 1'b0);
        check("R5 bad sig no pulse", 64'(off_req), 0);
        check("R5 bad sig len", 64'(rsp_len), 1);
        send(8'h7E, 5, pk(8'h4D, 8'h41, 8'h54, 8'h54, 0, 0), 1'b0);
        check("R11 off count", 64'({off_req, 3'(rsp_len)}), 0);

        // R6 reboot, R11 wrong count
        send(8'hD0, 0, '0, 1'b0);
        check("R6 reset pulse", 64'(rst_req), 1);
        check("R6 len", 64'(rsp_len), 0);
        send(8'hD0, 1, '0, 1'b0);
        check("R11 reboot count", 64'(rst_req), 0);

        // R7 constant queries across counts
        for (int n = 0; n < 3; n++) begin
            send(8'hEA, n, pk(8'hFF, 8'hFF, 0, 0, 0, 0), 1'b0);
            check("R7 version", 64'({5'(rsp_len), rsp_data}), 64'({5'd1, 32'h01}));
            send(8'hDC, n, '0, 1'b0);
            check("R7 cover", 64'({5'(rsp_len), rsp_data}), 64'({5'd1, 32'h00}));
            send(8'hE2, n, '0, 1'b0);
            check("R7 download", 64'({5'(rsp_len), rsp_data}), 64'({5'd1, 32'h62}));
        end

        // R8 power-event subcommand sweep
        for (int s = 0; s < 8; s++) begin
            send(8'h8F, 1, pk(8'(s), 0, 0, 0, 0, 0), 1'b0);
            check("R8 length", 64'(rsp_len), (s == 0 || s == 3) ? 64'd2 : 64'd0);
            check("R8 data", 64'(rsp_data), 0);
        end
        send(8'h8F, 0, '0, 1'b0);
        check("R11 power no args", 64'(rsp_len), 0);

        // R9 autopoll
        send(8'h20, 4, pk(8'h00, 8'h86, 8'h12, 8'h34, 0, 0), 1'b0);
        check("R9 enable", 64'({apoll_en, apoll_mask}), 64'({1'b1, 16'h1234}));
        check("R9 no forward", 64'({fwd_valid, 3'(rsp_len)}), 0);
        send(8'h20, 4, pk(8'h00, 8'h86, 8'h00, 8'h00, 0, 0), 1'b0);
        check("R9 disable keeps mask", 64'({apoll_en, apoll_mask}), 64'({1'b0, 16'h1234}));
        send(8'h20, 5, pk(8'h00, 8'h86, 8'hBE, 8'hEF, 0, 0), 1'b0);
        check("R11 autopoll count", 64'({apoll_en, apoll_mask, fwd_valid}), 64'({1'b0, 16'h1234, 1'b0}));

        // R10 forward, R11 bad forwards
        send(8'h20, 5, pk(8'h2C, 8'h00, 8'h02, 8'hAA, 8'hBB, 0), 1'b0);
        check("R10 pulse", 64'(fwd_valid), 1);
        check("R10 len", 64'(fwd_len), 3);
        check("R10 bytes", 64'(fwd_data[23:0]), 64'h00BBAA2C);
        check("R10 reply", 64'(rsp_len), 0);
        send(8'h20, 3, pk(8'h00, 8'h2C, 8'h00, 8'h11, 0, 0), 1'b0);
        check("R10 zero-prefix forward", 64'({fwd_valid, 6'(fwd_len), fwd_data[7:0]}), 64'({1'b1, 6'd1, 8'h00}));
        send(8'h20, 5, pk(8'h2C, 8'h00, 8'h03, 8'hAA, 8'hBB, 0), 1'b0);
        check("R11 forward overlong", 64'(fwd_valid), 0);
        send(8'h20, 1, pk(8'h2C, 0, 0, 0, 0, 0), 1'b0);
        check("R11 forward short", 64'(fwd_valid), 0);

        // R12 unknown-opcode sweep
        for (int op = 0; op < 256; op++) begin
            if (!is_known(8'(op))) begin
                send(8'(op), 2, pk(8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'hFF), 1'b0);
                check("R12 fill len", 64'(rsp_len), (op >= 192) ? 64'd0 : 64'(op % 4));
                check("R12 fill data", 64'(rsp_data), 0);
            end
        end
        check("R11 unknown leaves autopoll", 64'({apoll_en, apoll_mask}), 64'({1'b0, 16'h1234}));
        read_clock("R4 clock after sweep");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule